// File: doc/BRIEF.md
# Freezable Watchdog With Mode Hold

This block is a down-counting watchdog timer for a chip with several power modes: run, wait, doze and stop. Software arms it with a reload value and keeps it alive by writing a two-word service key. If the count runs out while the timer is live, the block raises a reset request. When that request arrives while the chip sleeps, the block also raises a wake request.

In stop mode the count is frozen. In wait and doze the count is frozen only when a programmable control bit asks for it. On returning to a mode where it is live, the count carries on from the exact value it held. It does not reload. Service writes that arrive during a freeze are consumed and discarded. Clock gating and the reset circuitry that acts on the request are outside this block.

The service port uses a valid/ready handshake. `svc_ready` is held high at all times, so the port never applies back-pressure. A beat is taken on every clock edge where `svc_valid` is high, whether or not the timer is frozen.

Top module: `holdable_watchdog`

## Requirements
- R1: While `en` is low, `count` loads `reload` on every edge, the service sequence is cleared, and neither request is raised.
- R2: With `en` high and `pmode` = 2'b11 (stop), `count` holds its value whatever `frz_lp` is.
- R3: With `pmode` = 2'b01 (wait) or 2'b10 (doze), `count` holds when `frz_lp` is 1 and decrements once per cycle when `frz_lp` is 0.
- R4: With `en` high and the timer live (run mode 2'b00, or wait/doze with `frz_lp` 0), `count` decreases by one per cycle. After a freeze it resumes from the held value with no reload.
- R5: An accepted beat of 16'h5555 arms the sequence. The next accepted beat being 16'hAAAA loads `reload` into `count` at that edge. Any other accepted beat disarms the sequence without reloading.
- R6: Beats accepted while the count is frozen change neither `count` nor the armed state of the sequence.
- R7: When `count` is 0 and the timer is live (with no service completing), the next edge sets `rst_req` for exactly one cycle and loads `reload`, provided `reload` is nonzero.
- R8: `wake_req` pulses with `rst_req` only when `pmode` is not run at the expiring edge. Otherwise it stays low.
- R9: `svc_ready` is always 1.
- R10: After reset, `count` is 0, both requests are low and the sequence is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Watchdog enable |
| pmode | input | 2 | Power mode: 00 run, 01 wait, 10 doze, 11 stop |
| frz_lp | input | 1 | Freeze the count in wait and doze |
| reload | input | 16 | Reload value |
| svc_valid | input | 1 | Service beat valid |
| svc_data | input | 16 | Service beat data |
| svc_ready | output | 1 | Service beat ready (always 1) |
| count | output | 16 | Current count |
| rst_req | output | 1 | One-cycle reset request on expiry |
| wake_req | output | 1 | One-cycle wake request on expiry in a low-power mode |

## Verification
Every result is due one edge after its stimulus. A beat, an enable change or a mode change presented before an edge shows up in `count`, `rst_req` and `wake_req` right after that edge. Expiry is due on the edge after `count` reads 0. The bench drives inputs on the falling edge and compares all outputs against a behavioural model on every falling edge, so each check sees exactly one edge of effect. Directed checks also sample at falling edges, counting the edges since the stimulus, with hand-computed values for the holds, the resumes, the reloads and the pulses.

// File: rtl/hwd_pkg.sv
package hwd_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_WAIT = 2'b01,
    PM_DOZE = 2'b10,
    PM_STOP = 2'b11
  } pmode_e;
endpackage

// File: rtl/hwd_freeze.sv
module hwd_freeze
  import hwd_pkg::*;
(
  input  logic       en,
  input  logic [1:0] pmode,
  input  logic       frz_lp,
  output logic       frozen,
  output logic       lowpwr
);
  pmode_e mode;
  logic   sleep_light;

  always_comb begin
    mode        = pmode_e'(pmode);
    lowpwr      = (mode != PM_RUN);
    sleep_light = (mode == PM_WAIT) || (mode == PM_DOZE);
    frozen      = en && ((mode == PM_STOP) || (sleep_light && frz_lp));
  end
endmodule

// File: rtl/hwd_seq.sv
module hwd_seq #(
  parameter int W = 16,
  parameter logic [W-1:0] KEY_ARM  = 16'h5555,
  parameter logic [W-1:0] KEY_FIRE = 16'hAAAA
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         frozen,
  input  logic         beat,
  input  logic [W-1:0] data,
  output logic         svc_done
);
  logic armed;
  logic take;

  always_comb begin
    take     = en && !frozen && beat;
    svc_done = take && armed && (data == KEY_FIRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed <= 1'b0;
    else if (!en)   armed <= 1'b0;
    else if (take)  armed <= (data == KEY_ARM);
  end

  AST_FROZEN_ARM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frozen) |=> (armed == $past(armed))); // R6
  AST_DISABLED_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !armed); // R1
endmodule

// File: rtl/hwd_count.sv
module hwd_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         frozen,
  input  logic         lowpwr,
  input  logic         svc_done,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         rst_req,
  output logic         wake_req
);
  localparam logic [W-1:0] ONE = W'(1);
  logic expire;

  always_comb expire = en && !frozen && !svc_done && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      rst_req  <= expire;
      wake_req <= expire && lowpwr;
      if (!en)                  cnt <= reload;
      else if (frozen)          cnt <= cnt;
      else if (svc_done || expire) cnt <= reload;
      else                      cnt <= cnt - ONE;
    end
  end

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frozen) |=> (cnt == $past(cnt))); // R2
  AST_LIVE_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frozen && !svc_done && cnt != '0) |=> (cnt == $past(cnt) - ONE)); // R4
  AST_SERVICE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    svc_done |=> (cnt == $past(reload) && !rst_req)); // R5
  AST_NO_PULSE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> !rst_req); // R6
  AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(cnt) == '0 && $past(en))); // R7
  AST_WAKE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> rst_req); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!rst_req && cnt == $past(reload))); // R1
endmodule

// File: rtl/holdable_watchdog.sv
module holdable_watchdog #(
  parameter int W = 16,
  parameter logic [W-1:0] KEY_ARM  = 16'h5555,
  parameter logic [W-1:0] KEY_FIRE = 16'hAAAA
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   pmode,
  input  logic         frz_lp,
  input  logic [W-1:0] reload,
  input  logic         svc_valid,
  input  logic [W-1:0] svc_data,
  output logic         svc_ready,
  output logic [W-1:0] count,
  output logic         rst_req,
  output logic         wake_req
);
  logic frozen, lowpwr, svc_done;

  assign svc_ready = 1'b1;

  hwd_freeze u_freeze (
    .en(en), .pmode(pmode), .frz_lp(frz_lp),
    .frozen(frozen), .lowpwr(lowpwr)
  );

  hwd_seq #(.W(W), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .frozen(frozen),
    .beat(svc_valid && svc_ready), .data(svc_data), .svc_done(svc_done)
  );

  hwd_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .en(en), .frozen(frozen), .lowpwr(lowpwr),
    .svc_done(svc_done), .reload(reload),
    .cnt(count), .rst_req(rst_req), .wake_req(wake_req)
  );

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ready); // R9
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pmode == 2'b11) |=> (count == $past(count))); // R2
endmodule

// File: tb/holdable_watchdog_test.sv
module holdable_watchdog_test;
  localparam int PERIOD = 20;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, frz_lp = 1'b0, svc_valid = 1'b0;
  logic [1:0] pmode = 2'b00;
  logic [15:0] reload = 16'd20, svc_data = 16'h0;
  logic svc_ready, rst_req, wake_req;
  logic [15:0] count;

  int checks = 0, errors = 0;
  string cur_req = "R10";
  int m_cnt = 0, m_armed = 0, m_rr = 0, m_wk = 0;
  bit started = 0;

  always #(PERIOD/2) clk = ~clk;

  holdable_watchdog uut (
    .clk(clk), .rst_n(rst_n), .en(en), .pmode(pmode), .frz_lp(frz_lp),
    .reload(reload), .svc_valid(svc_valid), .svc_data(svc_data),
    .svc_ready(svc_ready), .count(count), .rst_req(rst_req), .wake_req(wake_req)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_armed = 0; m_rr = 0; m_wk = 0;
    end else begin
      bit frz, done;
      frz = en && (pmode == 2'd3 || (pmode != 2'd0 && frz_lp));
      if (!en) begin
        m_cnt = reload; m_armed = 0; m_rr = 0; m_wk = 0;
      end else if (frz) begin
        m_rr = 0; m_wk = 0;
      end else begin
        done = svc_valid && svc_data == 16'hAAAA && m_armed != 0;
        if (svc_valid) m_armed = (svc_data == 16'h5555) ? 1 : 0;
        if (done) begin
          m_cnt = reload; m_rr = 0; m_wk = 0;
        end else if (m_cnt == 0) begin
          m_cnt = reload; m_rr = 1; m_wk = (pmode != 2'd0) ? 1 : 0;
        end else begin
          m_cnt = m_cnt - 1; m_rr = 0; m_wk = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    check(count == 16'(m_cnt), cur_req, count, m_cnt);
    check(rst_req == m_rr[0], cur_req, rst_req, m_rr);
    check(wake_req == m_wk[0], cur_req, wake_req, m_wk);
    check(svc_ready == 1'b1, "R9", svc_ready, 1);
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic beat(input logic [15:0] d);
    svc_valid = 1'b1; svc_data = d; tick(1); svc_valid = 1'b0;
  endtask

  initial begin
    #(PERIOD*100000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int held;
    @(negedge clk);
    check(count == 0 && !rst_req && !wake_req, "R10", count, 0);
    rst_n = 1'b1; started = 1;
    cur_req = "R1"; tick(3);
    check(count == 16'd20 && !rst_req, "R1", count, 20);
    cur_req = "R4"; en = 1'b1; tick(5);
    check(count == 16'd15, "R4", count, 15);
    cur_req = "R2"; pmode = 2'b11; tick(10);
    check(count == 16'd15, "R2", count, 15);
    frz_lp = 1'b1; tick(4);
    check(count == 16'd15, "R2", count, 15);
    cur_req = "R4"; pmode = 2'b00; frz_lp = 1'b0; tick(3);
    check(count == 16'd12, "R4 resume no reload", count, 12);
    cur_req = "R3"; pmode = 2'b01; frz_lp = 1'b1; tick(5);
    check(count == 16'd12, "R3 wait frozen", count, 12);
    pmode = 2'b10; frz_lp = 1'b0; tick(4);
    check(count == 16'd8, "R3 doze live", count, 8);
    cur_req = "R5"; pmode = 2'b00;
    beat(16'h5555); beat(16'hAAAA);
    check(count == 16'd20, "R5 service reload", count, 20);
    beat(16'h5555); beat(16'h1234); beat(16'hAAAA);
    check(count == 16'd17, "R5 broken key", count, 17);
    cur_req = "R6"; beat(16'h5555);
    held = count; pmode = 2'b11;
    beat(16'h1234); beat(16'hAAAA); tick(2);
    check(count == 16'(held), "R6 frozen beats", count, held);
    pmode = 2'b00; beat(16'hAAAA);
    check(count == 16'd20, "R6 armed kept", count, 20);
    cur_req = "R7"; reload = 16'd6; tick(20);
    held = count; tick(held);
    check(count == 0, "R7 at zero", count, 0);
    tick(1);
    check(rst_req && !wake_req && count == 16'd6, "R7 pulse", count, 6);
    tick(1);
    check(!rst_req, "R7 one cycle", rst_req, 0);
    cur_req = "R8"; pmode = 2'b10; tick(count);
    tick(1);
    check(rst_req && wake_req, "R8 wake in doze", wake_req, 1);
    tick(1);
    check(!wake_req, "R8 wake one cycle", wake_req, 0);
    cur_req = "R1"; en = 1'b0; reload = 16'd9; tick(2);
    check(count == 16'd9 && !rst_req, "R1 disable", count, 9);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule